// File: doc/BRIEF.md
# Extended Private Interrupt Set-Active Register Bank

This block keeps the active flags of 64 extended private peripheral interrupts that belong to one redistributor. Software sees the flags as two 32-bit words in a register frame. Writing a 1 to a bit makes the matching interrupt active. Writing a 0 does nothing. A read returns the current active flags.

Several things decide whether an access can see or change a bit:
- whether the interrupt is implemented,
- its security group together with the security attribute of the access,
- a global security-disable control,
- a per-security-state affinity-routing enable,
- a global enable for the extended-interrupt feature.

A bit that an access may not touch reads as zero, and writes to it are dropped. The interrupt-handling core can also set or clear any flag directly through a side port.

Top module: `isact_bank`

## Requirements
- R1: While `rst_n` is low, every active flag is cleared to 0 and `acc_rdata` is 0.
- R2: Offset 0x304 holds interrupts 0 to 31, with bit x standing for interrupt x. Offset 0x308 holds interrupts 32 to 63, with bit x standing for interrupt 32+x. Any other offset reads as 0 and ignores writes.
- R3: A write sets the flag of every visible bit written as 1. A bit written as 0 is left unchanged. A flag that is already set stays set.
- R4: A read with `acc_re` high returns the visible active flags of the addressed word on `acc_rdata` one cycle later. In any cycle after a cycle with `acc_re` low, `acc_rdata` is 0.
- R5: Consider a non-secure access (`acc_ns`=1) while `sec_dis`=0. To that access, bits of interrupts with `irq_grp_ns`=0 (Secure group) read as 0 and ignore writes. When `sec_dis`=1, or when the access is secure, those bits are visible.
- R6: Bits of interrupts with `irq_impl`=0 read as 0 and ignore writes.
- R7: For interrupts with `irq_grp_ns`=0, the bit is visible only while `aff_en_s` is 1. For interrupts with `irq_grp_ns`=1, the bit is visible only while `aff_en_ns` is 1. A bit that is not visible reads as 0 and ignores writes.
- R8: While `ext_en` is 0, every offset reads as 0 and ignores writes.
- R9: `core_set` sets flags and `core_clr` clears them.
  - When both hit the same bit in the same cycle, the clear wins.
  - A software set in the same cycle beats a core clear.
  - Flags change through nothing other than software sets and the side port.
- R10: `active_o` shows the stored flags, one bit per interrupt, with no masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 12 | Byte offset within the register frame |
| acc_wdata | input | 32 | Write data |
| acc_we | input | 1 | Write enable |
| acc_re | input | 1 | Read enable |
| acc_ns | input | 1 | 1 = non-secure access |
| acc_rdata | output | 32 | Registered read data |
| ext_en | input | 1 | Extended-interrupt feature enable |
| sec_dis | input | 1 | Global security-disable control |
| aff_en_s | input | 1 | Affinity routing enabled for the Secure state |
| aff_en_ns | input | 1 | Affinity routing enabled for the Non-secure state |
| irq_grp_ns | input | 64 | Per interrupt: 1 = non-secure group, 0 = secure |
| irq_impl | input | 64 | Per interrupt: 1 = implemented |
| core_set | input | 64 | Core-side set strobes |
| core_clr | input | 64 | Core-side clear strobes |
| active_o | output | 64 | Stored active flags |

## Verification
The set path is tried with several access types:
- all-ones writes from a non-secure access, which separate secure from non-secure bits;
- byte-wide writes from a secure access, which expose an unimplemented bit inside the written field;
- all-zero writes, which must leave the state unchanged;
- writes to the offsets just below and just above the two words, which must not alias into them.

The same stored pattern is then read with each gating control toggled in turn. This tells apart a bit that is hidden by security, by affinity routing, by implementation or by the feature enable from one that was never set. Simultaneous software and core strobes on one bit pin down which source wins.

// File: rtl/isact_bank.sv
module isact_bank #(
  parameter int WORDS = 2,
  parameter int W = 32,
  parameter int AW = 12,
  parameter logic [AW-1:0] BASE_OFS = 12'h300,
  parameter int FIRST_N = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       acc_addr,
  input  logic [W-1:0]        acc_wdata,
  input  logic                acc_we,
  input  logic                acc_re,
  input  logic                acc_ns,
  output logic [W-1:0]        acc_rdata,
  input  logic                ext_en,
  input  logic                sec_dis,
  input  logic                aff_en_s,
  input  logic                aff_en_ns,
  input  logic [WORDS*W-1:0]  irq_grp_ns,
  input  logic [WORDS*W-1:0]  irq_impl,
  input  logic [WORDS*W-1:0]  core_set,
  input  logic [WORDS*W-1:0]  core_clr,
  output logic [WORDS*W-1:0]  active_o
);
  localparam int NI = WORDS * W;
  localparam logic [AW-1:0] LO_OFS = BASE_OFS + AW'(4 * FIRST_N);
  localparam logic [AW-1:0] HI_OFS = BASE_OFS + AW'(4 * (FIRST_N + WORDS));

  logic [NI-1:0]    act_q, vis, wr_set;
  logic [WORDS-1:0] hit;
  logic [W-1:0]     rd_mux, rd_q;

  wire sec_open = !(acc_ns && !sec_dis);

  assign vis = irq_impl &
               ((irq_grp_ns & {NI{aff_en_ns}}) |
                (~irq_grp_ns & {NI{aff_en_s & sec_open}}));

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [AW-1:0] OFS = BASE_OFS + AW'(4 * (FIRST_N + g));
    assign hit[g] = ext_en && (acc_addr == OFS);
    assign wr_set[g*W +: W] = {W{acc_we & hit[g]}} & acc_wdata & vis[g*W +: W];
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < WORDS; i++)
      rd_mux |= {W{hit[i]}} & act_q[i*W +: W] & vis[i*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      rd_q  <= '0;
    end else begin
      act_q <= ((act_q | core_set) & ~core_clr) | wr_set;
      rd_q  <= acc_re ? rd_mux : '0;
    end
  end

  assign acc_rdata = rd_q;
  assign active_o  = act_q;
endmodule

module isact_bank_chk #(
  parameter int NI = 64,
  parameter int W = 32,
  parameter int AW = 12,
  parameter logic [AW-1:0] LO = 12'h304,
  parameter logic [AW-1:0] HI = 12'h30C
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] acc_addr,
  input logic [W-1:0]  acc_wdata,
  input logic          acc_we,
  input logic          acc_re,
  input logic          ext_en,
  input logic [NI-1:0] core_set,
  input logic [NI-1:0] core_clr,
  input logic [NI-1:0] active_o,
  input logic [W-1:0]  acc_rdata
);
  wire idle_core = (core_set == '0) && (core_clr == '0);
  wire off_range = (acc_addr < LO) || (acc_addr >= HI) || (acc_addr[1:0] != 2'b00);
  wire [NI-1:0] core_only = core_set & ~core_clr;

  // R1
  rst_rdata_chk: assert property (@(posedge clk) !rst_n |=> acc_rdata == '0 && active_o == '0);

  // R3
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_core && (!acc_we || acc_wdata == '0)) |=> $stable(active_o));

  // R4
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_re |=> acc_rdata == '0);

  // R2
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_re && off_range) |=> acc_rdata == '0);

  // R8
  feat_off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_re && !ext_en) |=> acc_rdata == '0);

  // R8
  feat_off_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && idle_core) |=> $stable(active_o));

  // R9
  clear_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clr == '0) |=> (($past(active_o) & ~active_o) == '0));

  // R9
  core_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((active_o & $past(core_only)) == $past(core_only)));
endmodule

bind isact_bank isact_bank_chk #(.NI(NI), .W(W), .AW(AW), .LO(LO_OFS), .HI(HI_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
  .acc_we(acc_we), .acc_re(acc_re), .ext_en(ext_en), .core_set(core_set),
  .core_clr(core_clr), .active_o(active_o), .acc_rdata(acc_rdata)
);

// File: tb/test_isact_bank.sv
`timescale 1ns/1ps
module test_isact_bank;
  logic        clk = 0, rst_n = 0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0, acc_rdata;
  logic        acc_we = 0, acc_re = 0, acc_ns = 0;
  logic        ext_en = 1, sec_dis = 0, aff_en_s = 1, aff_en_ns = 1;
  logic [63:0] irq_grp_ns, irq_impl, core_set = '0, core_clr = '0, active_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  isact_bank i_isact_bank (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_we(acc_we), .acc_re(acc_re), .acc_ns(acc_ns), .acc_rdata(acc_rdata),
    .ext_en(ext_en), .sec_dis(sec_dis), .aff_en_s(aff_en_s), .aff_en_ns(aff_en_ns),
    .irq_grp_ns(irq_grp_ns), .irq_impl(irq_impl), .core_set(core_set),
    .core_clr(core_clr), .active_o(active_o)
  );

  // {we, ns, addr, wdata, expected read}
  localparam int NV = 17;
  localparam logic [77:0] VEC [NV] = '{
    {1'b0, 1'b1, 12'h304, 32'h0,         32'h0},         // R1 reset state
    {1'b1, 1'b1, 12'h304, 32'hFFFF_FFFF, 32'h0},         // R3 R5 ns write
    {1'b0, 1'b1, 12'h304, 32'h0,         32'hFFFF_0000}, // R5
    {1'b0, 1'b0, 12'h304, 32'h0,         32'hFFFF_0000}, // R4
    {1'b1, 1'b0, 12'h304, 32'h0000_00FF, 32'h0},         // R6 bit 5 absent
    {1'b0, 1'b0, 12'h304, 32'h0,         32'hFFFF_00DF}, // R6
    {1'b0, 1'b1, 12'h304, 32'h0,         32'hFFFF_0000}, // R5
    {1'b1, 1'b0, 12'h304, 32'h0,         32'h0},         // R3 zero write
    {1'b0, 1'b0, 12'h304, 32'h0,         32'hFFFF_00DF}, // R3
    {1'b1, 1'b1, 12'h308, 32'h8000_0001, 32'h0},         // R2 R6 bit 63 absent
    {1'b0, 1'b1, 12'h308, 32'h0,         32'h0000_0001}, // R2
    {1'b1, 1'b0, 12'h300, 32'hFFFF_FFFF, 32'h0},         // R2 below range
    {1'b0, 1'b0, 12'h300, 32'h0,         32'h0},         // R2
    {1'b1, 1'b0, 12'h30C, 32'hFFFF_FFFF, 32'h0},         // R2 above range
    {1'b0, 1'b0, 12'h30C, 32'h0,         32'h0},         // R2
    {1'b0, 1'b0, 12'h304, 32'h0,         32'hFFFF_00DF}, // R2
    {1'b0, 1'b0, 12'h308, 32'h0,         32'h0000_0001}  // R2
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic ns, input logic [11:0] a,
                    input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    acc_we = we; acc_re = !we; acc_ns = ns; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    rd = acc_rdata;
    acc_we = 0; acc_re = 0; acc_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic ns, input logic [11:0] a,
                        input logic [31:0] exp);
    logic [31:0] r;
    op(1'b0, ns, a, 32'h0, r);
    chk(req, {32'h0, r}, {32'h0, exp});
  endtask

  task automatic core_pulse(input logic [63:0] s, input logic [63:0] c);
    @(negedge clk); core_set = s; core_clr = c;
    @(negedge clk); core_set = '0; core_clr = '0;
  endtask

  initial begin
    logic [31:0] r;
    irq_grp_ns = {{48{1'b1}}, 16'h0};
    irq_impl   = ~64'h0 & ~(64'h1 << 63) & ~(64'h1 << 5);
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", {32'h0, acc_rdata}, 64'h0);
    chk("R1 flags in reset", active_o, 64'h0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][77], VEC[i][76], VEC[i][75:64], VEC[i][63:32], r);
      if (!VEC[i][77]) chk($sformatf("R4 table step %0d", i), {32'h0, r}, {32'h0, VEC[i][31:0]});
    end
    chk("R10 stored flags", active_o, {32'h1, 32'hFFFF_00DF});

    @(negedge clk);
    chk("R4 idle rdata", {32'h0, acc_rdata}, 64'h0);

    sec_dis = 1;
    rd_chk("R5 security disabled", 1'b1, 12'h304, 32'hFFFF_00DF);
    sec_dis = 0;

    aff_en_s = 0;
    rd_chk("R7 secure routing off", 1'b0, 12'h304, 32'hFFFF_0000);
    op(1'b1, 1'b0, 12'h304, 32'h0000_0100, r);
    aff_en_s = 1;
    rd_chk("R7 write ignored", 1'b0, 12'h304, 32'hFFFF_00DF);
    aff_en_ns = 0;
    rd_chk("R7 ns routing off", 1'b0, 12'h304, 32'h0000_00DF);
    aff_en_ns = 1;

    ext_en = 0;
    rd_chk("R8 feature off read", 1'b0, 12'h304, 32'h0);
    op(1'b1, 1'b0, 12'h308, 32'hFFFF_FFFF, r);
    ext_en = 1;
    rd_chk("R8 feature off write", 1'b0, 12'h308, 32'h0000_0001);

    @(negedge clk);
    core_clr = 64'h1 << 16;
    acc_we = 1; acc_ns = 0; acc_addr = 12'h304; acc_wdata = 32'h0001_0000;
    @(negedge clk);
    core_clr = '0; acc_we = 0; acc_wdata = '0;
    rd_chk("R9 sw set beats core clear", 1'b0, 12'h304, 32'hFFFF_00DF);
    core_pulse('0, 64'h1 << 17);
    rd_chk("R9 core clear", 1'b0, 12'h304, 32'hFFFD_00DF);
    core_pulse(64'h1 << 40, '0);
    rd_chk("R9 core set", 1'b0, 12'h308, 32'h0000_0101);
    core_pulse(64'h1 << 41, 64'h1 << 41);
    rd_chk("R9 clear beats core set", 1'b0, 12'h308, 32'h0000_0101);
    core_pulse(64'h1 << 63, '0);
    chk("R10 raw flag unmasked", {63'h0, active_o[63]}, 64'h1);
    rd_chk("R6 absent bit hidden", 1'b0, 12'h308, 32'h0000_0101);

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 flags after reset", active_o, 64'h0);
    rd_chk("R1 read after reset", 1'b0, 12'h304, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule